// File: doc/BRIEF.md
# Serial DMA Register and Status Front End

This block is the register and status front end of a DMA controller that moves data between main memory and a small serial-side RAM. Software sees six 32-bit registers on a simple bus with a byte offset, read and write strobes, write data and combinational read data. Two of them hold the transfer addresses: a 24-bit main-memory address and a word address into a 2 KB side RAM. Three offsets start a transfer when written. A fourth offset only updates the side-RAM address and never launches anything.

The block tracks the DMA busy, IO busy, read-pending and sticky error flags, and it drives one interrupt line. A transfer engine outside the block takes a one-cycle start pulse with a transfer kind and the two addresses, and reports completion on a done input. Direct IO reads of the side RAM arrive on a request input. A read that arrives while a write into the side RAM is running is held back and released when that write completes.

Top module: `serdma_ctrl`

## Requirements
- R1: The main-memory address register sits at offset 0x00. It keeps bits 23:0 of the written data, reads bits 31:24 as zero, resets to zero, and drives `eng_mem_addr`.
- R2: The side-RAM word address is one field that offsets 0x04, 0x08, 0x10 and 0x14 share. Write data bits 10:2 load it. Reads place it at bits 10:2 with every other bit zero, and `eng_side_addr` carries the 9-bit word index.
- R3: A write to 0x04 while no DMA is busy loads the side address and pulses `eng_start` for exactly one cycle after the write edge, with `eng_kind` = 0 (block read). DMA busy then reads as 1.
- R4: A write to 0x10 while no DMA is busy starts a transfer with `eng_kind` = 1 (block write) and sets DMA busy.
- R5: A write to 0x08 while no DMA is busy starts a transfer with `eng_kind` = 2 (single-word write into the side RAM) and sets both DMA busy and IO busy.
- R6: A write to 0x14 updates the side address field only. It produces no start pulse and leaves every status flag unchanged.
- R7: A start write (0x04, 0x08 or 0x10) that arrives while DMA busy is set is dropped. No pulse is produced and the side address is unchanged, and the error flag is set. The error flag stays set through later transfers and interrupt clears, and only reset clears it.
- R8: `eng_done` while DMA busy is set clears DMA busy and IO busy and raises `irq` from the next cycle. `eng_done` while idle has no effect.
- R9: A write of any data to the status offset 0x18 clears `irq`. If a completion arrives in the same cycle, the interrupt stays raised.
- R10: An `io_rd_req` that arrives while a block write or a word write is in progress sets read pending and issues nothing. When that transfer completes, read pending clears and `io_rd_go` pulses for one cycle.
- R11: An `io_rd_req` that arrives while no write is in progress, including during a block read, pulses `io_rd_go` in the next cycle and leaves read pending clear.
- R12: The status register at 0x18 has irq at bit 12, error at bit 3, read pending at bit 2, IO busy at bit 1 and DMA busy at bit 0. All other bits read zero, and the whole register reads zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Register byte offset |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read is strobed |
| eng_start | output | 1 | One-cycle transfer launch to the engine |
| eng_kind | output | 2 | Transfer kind: 0 block read, 1 block write, 2 word write |
| eng_mem_addr | output | 24 | Main-memory address |
| eng_side_addr | output | 9 | Side-RAM word index |
| eng_done | input | 1 | Engine reports the running transfer finished |
| io_rd_req | input | 1 | A direct IO read of the side RAM arrives |
| io_rd_go | output | 1 | One-cycle release of an IO read to the engine |
| irq | output | 1 | Interrupt line |

## Verification
The hardest state to reach from the ports is a held IO read. It needs a write transfer that is still running when the read request arrives, and then a completion that releases the read. The stimulus starts a block write, holds off `eng_done` while it pulses `io_rd_req`, and checks that read pending is set and that `io_rd_go` stays low. After that it delivers the completion and looks for the release pulse. A second hard case makes a completion and an interrupt-clearing status write land on the same edge, to confirm that the new completion keeps the interrupt raised.

// File: rtl/serdma_pkg.sv
package serdma_pkg;

    localparam int unsigned OFF_W = 5;

    localparam logic [OFF_W-1:0] OFF_MEMADDR = 5'h00;
    localparam logic [OFF_W-1:0] OFF_BLK_RD  = 5'h04;
    localparam logic [OFF_W-1:0] OFF_WORD_WR = 5'h08;
    localparam logic [OFF_W-1:0] OFF_BLK_WR  = 5'h10;
    localparam logic [OFF_W-1:0] OFF_WORD_RD = 5'h14;
    localparam logic [OFF_W-1:0] OFF_STATUS  = 5'h18;

    localparam int unsigned BIT_IRQ  = 12;
    localparam int unsigned BIT_ERR  = 3;
    localparam int unsigned BIT_PEND = 2;
    localparam int unsigned BIT_IOB  = 1;
    localparam int unsigned BIT_DMAB = 0;

    typedef enum logic [1:0] {
        XFER_BLK_RD  = 2'd0,
        XFER_BLK_WR  = 2'd1,
        XFER_WORD_WR = 2'd2
    } xfer_kind_e;

    typedef struct packed {
        logic       wr_mem;
        logic       wr_side;
        logic       start;
        xfer_kind_e kind;
        logic       wr_status;
    } bus_evt_t;

endpackage

// File: rtl/serdma_decode.sv
module serdma_decode
    import serdma_pkg::*;
(
    input  logic             bus_wr,
    input  logic [OFF_W-1:0] bus_addr,
    output bus_evt_t         evt
);

    always_comb begin
        evt = '{wr_mem: 1'b0, wr_side: 1'b0, start: 1'b0,
                kind: XFER_BLK_RD, wr_status: 1'b0};
        if (bus_wr) begin
            case (bus_addr)
                OFF_MEMADDR: evt.wr_mem = 1'b1;
                OFF_BLK_RD: begin
                    evt.wr_side = 1'b1;
                    evt.start   = 1'b1;
                    evt.kind    = XFER_BLK_RD;
                end
                OFF_BLK_WR: begin
                    evt.wr_side = 1'b1;
                    evt.start   = 1'b1;
                    evt.kind    = XFER_BLK_WR;
                end
                OFF_WORD_WR: begin
                    evt.wr_side = 1'b1;
                    evt.start   = 1'b1;
                    evt.kind    = XFER_WORD_WR;
                end
                OFF_WORD_RD: evt.wr_side   = 1'b1;
                OFF_STATUS:  evt.wr_status = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/serdma_addr_regs.sv
module serdma_addr_regs #(
    parameter int unsigned MEM_AW  = 24,
    parameter int unsigned SIDE_AW = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_mem,
    input  logic               side_load,
    input  logic [MEM_AW-1:0]  mem_wdata,
    input  logic [SIDE_AW-1:0] side_wdata,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic [SIDE_AW-1:0] side_word
);

    typedef struct packed {
        logic [MEM_AW-1:0]  mem;
        logic [SIDE_AW-1:0] side;
    } addr_state_t;

    addr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_mem)    st_d.mem  = mem_wdata;
        if (side_load) st_d.side = side_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_addr  = st_q.mem;
    assign side_word = st_q.side;

endmodule

// File: rtl/serdma_flags.sv
module serdma_flags
    import serdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  bus_evt_t   evt,
    input  logic       eng_done,
    input  logic       io_rd_req,
    output logic       side_load,
    output logic       start_pulse,
    output xfer_kind_e start_kind,
    output logic       dma_busy,
    output logic       io_busy,
    output logic       wr_busy,
    output logic       err_flag,
    output logic       pend_flag,
    output logic       irq_flag,
    output logic       rd_go
);

    typedef struct packed {
        logic       dma_busy;
        logic       io_busy;
        logic       wr_busy;
        logic       err;
        logic       pend;
        logic       irq;
        logic       start;
        xfer_kind_e kind;
        logic       rd_go;
    } flag_state_t;

    flag_state_t st_d, st_q;

    logic done_now;
    logic start_ok;
    logic start_clash;
    logic rd_blocked;

    always_comb begin
        done_now    = eng_done && st_q.dma_busy;
        start_ok    = evt.start && !st_q.dma_busy;
        start_clash = evt.start && st_q.dma_busy;
        rd_blocked  = st_q.wr_busy && !done_now;

        st_d       = st_q;
        st_d.start = 1'b0;
        st_d.rd_go = 1'b0;

        // completion of the running transfer
        if (done_now) begin
            st_d.dma_busy = 1'b0;
            st_d.io_busy  = 1'b0;
            st_d.wr_busy  = 1'b0;
        end

        // interrupt: clear by status write, a fresh completion wins
        if (evt.wr_status) st_d.irq = 1'b0;
        if (done_now)      st_d.irq = 1'b1;

        // sticky overlap error
        if (start_clash) st_d.err = 1'b1;

        // launch
        if (start_ok) begin
            st_d.dma_busy = 1'b1;
            st_d.io_busy  = (evt.kind == XFER_WORD_WR);
            st_d.wr_busy  = (evt.kind != XFER_BLK_RD);
            st_d.start    = 1'b1;
            st_d.kind     = evt.kind;
        end

        // held IO read release once no write blocks it
        if (st_q.pend && !rd_blocked) begin
            st_d.pend  = 1'b0;
            st_d.rd_go = 1'b1;
        end

        // new IO read: hold behind a write or behind an older held read
        if (io_rd_req) begin
            if (rd_blocked || st_q.pend) st_d.pend  = 1'b1;
            else                         st_d.rd_go = 1'b1;
        end

        side_load = evt.wr_side && !start_clash;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{kind: XFER_BLK_RD, default: 1'b0};
        else        st_q <= st_d;
    end

    assign start_pulse = st_q.start;
    assign start_kind  = st_q.kind;
    assign dma_busy    = st_q.dma_busy;
    assign io_busy     = st_q.io_busy;
    assign wr_busy     = st_q.wr_busy;
    assign err_flag    = st_q.err;
    assign pend_flag   = st_q.pend;
    assign irq_flag    = st_q.irq;
    assign rd_go       = st_q.rd_go;

endmodule

// File: rtl/serdma_ctrl.sv
module serdma_ctrl
    import serdma_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned MEM_AW  = 24,
    parameter int unsigned SIDE_AW = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OFF_W-1:0]   bus_addr,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               eng_start,
    output logic [1:0]         eng_kind,
    output logic [MEM_AW-1:0]  eng_mem_addr,
    output logic [SIDE_AW-1:0] eng_side_addr,
    input  logic               eng_done,
    input  logic               io_rd_req,
    output logic               io_rd_go,
    output logic               irq
);

    localparam int unsigned SIDE_LSB = 2;
    localparam int unsigned SIDE_MSB = SIDE_AW + SIDE_LSB - 1;

    generate
        if (MEM_AW >= DATA_W || SIDE_MSB >= DATA_W || BIT_IRQ >= DATA_W) begin : g_bad_cfg
            $error("serdma_ctrl: address fields do not fit in the data word");
        end
    endgenerate

    bus_evt_t           evt;
    logic               side_load;
    logic [MEM_AW-1:0]  mem_addr;
    logic [SIDE_AW-1:0] side_word;
    logic               start_pulse;
    xfer_kind_e         start_kind;
    logic               dma_busy;
    logic               io_busy;
    logic               wr_busy;
    logic               err_flag;
    logic               pend_flag;
    logic               irq_flag;
    logic               rd_go;
    logic [DATA_W-1:0]  rd_word;
    logic               unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:MEM_AW];

    serdma_decode u_decode (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .evt      (evt)
    );

    serdma_addr_regs #(
        .MEM_AW  (MEM_AW),
        .SIDE_AW (SIDE_AW)
    ) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_mem     (evt.wr_mem),
        .side_load  (side_load),
        .mem_wdata  (bus_wdata[MEM_AW-1:0]),
        .side_wdata (bus_wdata[SIDE_MSB:SIDE_LSB]),
        .mem_addr   (mem_addr),
        .side_word  (side_word)
    );

    serdma_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt         (evt),
        .eng_done    (eng_done),
        .io_rd_req   (io_rd_req),
        .side_load   (side_load),
        .start_pulse (start_pulse),
        .start_kind  (start_kind),
        .dma_busy    (dma_busy),
        .io_busy     (io_busy),
        .wr_busy     (wr_busy),
        .err_flag    (err_flag),
        .pend_flag   (pend_flag),
        .irq_flag    (irq_flag),
        .rd_go       (rd_go)
    );

    always_comb begin
        rd_word = '0;
        case (bus_addr)
            OFF_MEMADDR: rd_word[MEM_AW-1:0] = mem_addr;
            OFF_BLK_RD, OFF_WORD_WR, OFF_BLK_WR, OFF_WORD_RD:
                rd_word[SIDE_MSB:SIDE_LSB] = side_word;
            OFF_STATUS: begin
                rd_word[BIT_IRQ]  = irq_flag;
                rd_word[BIT_ERR]  = err_flag;
                rd_word[BIT_PEND] = pend_flag;
                rd_word[BIT_IOB]  = io_busy;
                rd_word[BIT_DMAB] = dma_busy;
            end
            default: ;
        endcase
        bus_rdata = bus_rd ? rd_word : '0;
    end

    assign eng_start     = start_pulse;
    assign eng_kind      = start_kind;
    assign eng_mem_addr  = mem_addr;
    assign eng_side_addr = side_word;
    assign io_rd_go      = rd_go;
    assign irq           = irq_flag;

endmodule

// File: rtl/serdma_ctrl_chk.sv
module serdma_ctrl_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              eng_start,
    input logic [1:0]        eng_kind,
    input logic              eng_done,
    input logic              io_rd_req,
    input logic              io_rd_go,
    input logic              irq,
    input logic              dma_busy,
    input logic              io_busy,
    input logic              wr_busy,
    input logic              err_flag,
    input logic              pend_flag
);

    // R1
    mem_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 5'h00) |-> (bus_rdata[DATA_W-1:24] == '0));

    // R3
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R5
    word_io_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start && eng_kind == 2'd2) |-> (io_busy && dma_busy));

    // R6
    word_rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 5'h14) |=> !eng_start);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    // R8
    done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && dma_busy) |=> (irq && !dma_busy));

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd_req && wr_busy && !eng_done && !pend_flag) |=> (pend_flag && !io_rd_go));

    // R11
    rd_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd_req && !wr_busy && !pend_flag) |=> io_rd_go);

endmodule

bind serdma_ctrl serdma_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .eng_start (eng_start),
    .eng_kind  (eng_kind),
    .eng_done  (eng_done),
    .io_rd_req (io_rd_req),
    .io_rd_go  (io_rd_go),
    .irq       (irq),
    .dma_busy  (dma_busy),
    .io_busy   (io_busy),
    .wr_busy   (wr_busy),
    .err_flag  (err_flag),
    .pend_flag (pend_flag)
);

// File: tb/test_serdma_ctrl.sv
`timescale 1ns/1ps
module test_serdma_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_start;
    logic [1:0]  eng_kind;
    logic [23:0] eng_mem_addr;
    logic [8:0]  eng_side_addr;
    logic        eng_done = 1'b0;
    logic        io_rd_req = 1'b0;
    logic        io_rd_go;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    serdma_ctrl i_serdma_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_addr      (bus_addr),
        .bus_rd        (bus_rd),
        .bus_wr        (bus_wr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .eng_start     (eng_start),
        .eng_kind      (eng_kind),
        .eng_mem_addr  (eng_mem_addr),
        .eng_side_addr (eng_side_addr),
        .eng_done      (eng_done),
        .io_rd_req     (io_rd_req),
        .io_rd_go      (io_rd_go),
        .irq           (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
    endtask

    task automatic pulse_rd();
        @(negedge clk); io_rd_req = 1'b1;
        @(negedge clk); io_rd_req = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        bus_read(5'h18, v); check("R12 status after reset", v, 32'h0);
        bus_read(5'h00, v); check("R1 mem addr after reset", v, 32'h0);
        check("R12 irq after reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_mem_addr();
        logic [31:0] v;
        bus_write(5'h00, 32'hFFAB_CDEF);
        bus_read(5'h00, v);
        check("R1 mem addr upper bits zero", v, 32'h00AB_CDEF);
        check("R1 mem addr to engine", {8'h0, eng_mem_addr}, 32'h00AB_CDEF);
    endtask

    task automatic t_side_only();
        logic [31:0] v;
        bus_write(5'h14, 32'hFFFF_FFFF);
        check("R6 no start from 0x14", {31'b0, eng_start}, 32'h0);
        bus_read(5'h18, v); check("R6 status untouched", v, 32'h0);
        bus_read(5'h14, v); check("R2 field at 0x14", v, 32'h0000_07FC);
        bus_read(5'h04, v); check("R2 field shared at 0x04", v, 32'h0000_07FC);
    endtask

    task automatic t_block_read();
        logic [31:0] v;
        bus_write(5'h04, 32'h0000_0123);
        check("R3 start pulse", {31'b0, eng_start}, 32'h1);
        check("R3 kind block read", {30'b0, eng_kind}, 32'h0);
        check("R3 side index", {23'b0, eng_side_addr}, 32'h48);
        @(negedge clk);
        check("R3 pulse one cycle", {31'b0, eng_start}, 32'h0);
        bus_read(5'h18, v); check("R3 dma busy", v, 32'h1);
        pulse_done();
        check("R8 irq raised", {31'b0, irq}, 32'h1);
        bus_read(5'h18, v); check("R8 busy clear irq set", v, 32'h1000);
        pulse_done();
        bus_read(5'h18, v); check("R8 idle done ignored", v, 32'h1000);
        bus_write(5'h18, 32'h0);
        check("R9 irq cleared", {31'b0, irq}, 32'h0);
        bus_read(5'h18, v); check("R9 status clear", v, 32'h0);
    endtask

    task automatic t_write_held_read();
        logic [31:0] v;
        bus_write(5'h10, 32'h0000_07FC);
        check("R4 start pulse", {31'b0, eng_start}, 32'h1);
        check("R4 kind block write", {30'b0, eng_kind}, 32'h1);
        pulse_rd();
        check("R10 read held", {31'b0, io_rd_go}, 32'h0);
        bus_read(5'h18, v); check("R10 pending set", v, 32'h5);
        pulse_done();
        check("R10 held read released", {31'b0, io_rd_go}, 32'h1);
        bus_read(5'h18, v); check("R10 pending clear", v, 32'h1000);
        check("R10 release one cycle", {31'b0, io_rd_go}, 32'h0);
        bus_write(5'h18, 32'hFFFF_FFFF);
        check("R9 any data clears", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_free_read();
        logic [31:0] v;
        pulse_rd();
        check("R11 idle read passes", {31'b0, io_rd_go}, 32'h1);
        bus_read(5'h18, v); check("R11 no pending idle", v, 32'h0);
        bus_write(5'h04, 32'h0);
        pulse_rd();
        check("R11 read passes during block read", {31'b0, io_rd_go}, 32'h1);
        bus_read(5'h18, v); check("R11 no pending in block read", v, 32'h1);
        pulse_done();
        bus_write(5'h18, 32'h0);
    endtask

    task automatic t_word_write();
        logic [31:0] v;
        bus_write(5'h08, 32'h0000_0010);
        check("R5 kind word write", {30'b0, eng_kind}, 32'h2);
        check("R5 start pulse", {31'b0, eng_start}, 32'h1);
        bus_read(5'h18, v); check("R5 io and dma busy", v, 32'h3);
        pulse_done();
        bus_read(5'h18, v); check("R5 done clears io busy", v, 32'h1000);
        bus_write(5'h18, 32'h0);
    endtask

    task automatic t_overlap();
        logic [31:0] v;
        bus_write(5'h04, 32'h0000_0040);
        bus_write(5'h10, 32'h0000_0080);
        check("R7 overlap dropped", {31'b0, eng_start}, 32'h0);
        check("R7 side addr kept", {23'b0, eng_side_addr}, 32'h10);
        bus_read(5'h18, v); check("R7 error set", v, 32'h9);
        pulse_done();
        bus_write(5'h18, 32'h0);
        bus_read(5'h18, v); check("R7 error survives irq clear", v, 32'h8);
        bus_write(5'h10, 32'h0);
        check("R7 later start accepted", {31'b0, eng_start}, 32'h1);
        pulse_done();
        bus_write(5'h18, 32'h0);
        bus_read(5'h18, v); check("R7 error still set", v, 32'h8);
        do_reset();
        bus_read(5'h18, v); check("R7 reset clears error", v, 32'h0);
    endtask

    task automatic t_clear_race();
        bus_write(5'h04, 32'h0);
        @(negedge clk);
        eng_done = 1'b1; bus_addr = 5'h18; bus_wdata = 32'h0; bus_wr = 1'b1;
        @(negedge clk);
        eng_done = 1'b0; bus_wr = 1'b0;
        check("R9 completion beats clear", {31'b0, irq}, 32'h1);
        bus_write(5'h18, 32'h0);
        check("R9 later clear", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_mem_addr();
        t_side_only();
        t_block_read();
        t_write_held_read();
        t_free_read();
        t_word_write();
        t_overlap();
        t_clear_race();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule